// File: doc/BRIEF.md
# Vectorised Condition Register File

This block stores the condition flags of a vector extension as sixteen 32-bit rows, each row split into eight 4-bit condition fields. It has one read port and one write path. Every access point names a location with the same three values: a 5-bit bit selector, a small extra specifier and a vector element index. The block turns these into a row, a column (field) and a bit inside that field. Consecutive elements of a vector therefore fall into consecutive rows of one column. Only after sixteen elements does the vector move on to the next column.

Two sources share the write path. A single-bit write port changes one flag. A vector sequencer accepts a command holding a selector, a specifier and a vector length VL. It then consumes one 4-bit flag nibble per element, for element indices 0 to VL-1, and writes each nibble into the field that its element maps to. The read port is combinational and returns both the addressed field and the addressed bit.

Back-pressure rules:
- The command port and the bit-write port use valid/ready and are ready only while the sequencer is idle.
- The flag stream is ready only while a vector is running.
- A transfer happens on a clock edge where valid and ready are both high.
- A source that sees ready low must hold its request. The request has no effect until it is accepted.

`done` is a plain one-cycle status pulse.

Top module: `vcr_file`

## Requirements
- R1: An active-low asynchronous reset clears all sixteen rows to zero.
- R2: The field number is 7 minus selector bits [4:2]. The bit inside the field is 3 minus selector bits [1:0], counted from the field's LSB. Column c of a row occupies row bits [4*(7-c)+3 : 4*(7-c)]. The read port presents this nibble on `rd_field` and the addressed bit on `rd_bit`.
- R3: With SPEC_W=2 the specifier is widened to {spec,0}. With SPEC_W=3 it is used as is. Only bits [2:1] of the 3-bit value take part in the address, so specifier bit 0 has no effect.
- R4: The row is (field + element index[3:0]) mod 16, so the row wraps past 15 to 0.
- R5: The column is (16*field + 4*spec3[2:1] + (index >> 4)) mod 8, which equals (4*spec3[1] + index[6:4]) mod 8.
- R6: An accepted bit write changes only the addressed bit. The other 31 bits of its row and all other rows keep their values.
- R7: In a vector command, each accepted flag nibble overwrites exactly the 4-bit field mapped from the command's selector, the command's specifier and the current element index. The elements take indices 0,1,2,... in order.
- R8: A vector of VL=18 writes elements 0..15 into sixteen distinct rows of one column. Elements 16 and 17 go into the next column, in the rows of elements 0 and 1, and nothing already written by the vector is overwritten.
- R9: `done` is high for exactly one cycle, in the cycle after the last element is written. A command with VL=0 writes nothing and raises `done` in the cycle after it is accepted.
- R10: A read of a location that is written at the same clock edge returns the value from before that edge.
- R11: `cmd_ready` and `bw_ready` are high only while idle, and `flag_ready` only while a vector runs (never in the `done` cycle). Requests without ready change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Vector command offered |
| cmd_ready | output | 1 | Command accepted this edge when valid |
| cmd_sel | input | 5 | Bit selector of the vector's base |
| cmd_spec | input | SPEC_W | Extra specifier for the vector |
| cmd_vl | input | IDX_W+1 | Vector length, 0 allowed |
| flag_valid | input | 1 | Flag nibble offered for the current element |
| flag_ready | output | 1 | Nibble accepted this edge when valid |
| flag_data | input | 4 | Flag nibble of the current element |
| done | output | 1 | One-cycle pulse when a vector completes |
| bw_valid | input | 1 | Single-bit write offered |
| bw_ready | output | 1 | Bit write accepted this edge when valid |
| bw_sel | input | 5 | Bit selector of the bit write |
| bw_spec | input | SPEC_W | Extra specifier of the bit write |
| bw_idx | input | IDX_W | Element index of the bit write |
| bw_data | input | 1 | Value of the written bit |
| rd_sel | input | 5 | Bit selector of the read |
| rd_spec | input | SPEC_W | Extra specifier of the read |
| rd_idx | input | IDX_W | Element index of the read |
| rd_field | output | 4 | Addressed 4-bit field |
| rd_bit | output | 1 | Addressed bit |

## Verification
A wrong row or column computation puts a flag into the wrong nibble. That error shows on `rd_field` the cycle after the write, as soon as the read port is pointed at either the intended or the actually written location. The bench sweeps reads across every row and column to catch both. A wrong element counter or sequencer state shows within one cycle as a mismatch on the ready signals or on `done`. A wrong count also makes a later element land in the wrong field, which the following read sweep exposes. Storage that changes without an accepted transfer is visible on the next read of that row.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int NROWS  = 16;
  localparam int NCOLS  = 8;
  localparam int FLD_W  = 4;
  localparam int ROW_W  = NCOLS * FLD_W;
  localparam int RIDX_W = $clog2(NROWS);
  localparam int CIDX_W = $clog2(NCOLS);
  localparam int BSEL_W = 5;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_FIN  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [RIDX_W-1:0] row;
    logic [CIDX_W-1:0] col;
    logic [1:0]        bitn;
  } vcr_loc_t;
endpackage

// File: rtl/vcr_addr.sv
module vcr_addr
  import vcr_pkg::*;
#(
  parameter int SPEC_W = 3,
  parameter int IDX_W  = 7
) (
  input  logic [BSEL_W-1:0] sel,
  input  logic [SPEC_W-1:0] spec,
  input  logic [IDX_W-1:0]  idx,
  output vcr_loc_t          loc
);
  logic [2:0]       spec3;
  logic [2:0]       field;
  logic [6:0]       ext;
  logic [IDX_W-1:0] idx_hi;

  // widen a short specifier with a zero LSB, otherwise take it unchanged
  generate
    if (SPEC_W == 2) begin : g_spec2
      assign spec3 = {spec, 1'b0};
    end else begin : g_spec3
      assign spec3 = spec;
    end
  endgenerate

  assign field  = 3'd7 - sel[4:2];
  assign ext    = 7'({field, 4'b0000}) | 7'({spec3 >> 1, 2'b00});
  assign idx_hi = idx >> 4;

  always_comb begin
    loc.row  = RIDX_W'(ext[6:4]) + idx[3:0];
    loc.col  = CIDX_W'(ext + 7'(idx_hi));
    loc.bitn = 2'd3 - sel[1:0];
  end
endmodule

// File: rtl/vcr_store.sv
module vcr_store
  import vcr_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [RIDX_W-1:0]              wrow,
  input  logic [CIDX_W-1:0]              wcol,
  input  logic [FLD_W-1:0]               wmask,
  input  logic [FLD_W-1:0]               wdata,
  input  logic [RIDX_W-1:0]              rrow,
  input  logic [CIDX_W-1:0]              rcol,
  output logic [FLD_W-1:0]               rfield,
  output logic [NROWS-1:0][ROW_W-1:0]    rows_q
);
  logic [ROW_W-1:0] mem [NROWS];
  logic [4:0]       wbase;
  logic [4:0]       rbase;

  // column c sits at bits 4*(7-c); ~c equals 7-c for three bits
  assign wbase = {~wcol, 2'b00};
  assign rbase = {~rcol, 2'b00};

  generate
    for (genvar r = 0; r < NROWS; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem[r] <= '0;
        end else if (we && (wrow == RIDX_W'(r))) begin
          mem[r][wbase +: FLD_W] <= (mem[r][wbase +: FLD_W] & ~wmask) | (wdata & wmask);
        end
      end
      assign rows_q[r] = mem[r];
    end
  endgenerate

  assign rfield = rows_q[rrow][rbase +: FLD_W];
endmodule

// File: rtl/vcr_seq.sv
module vcr_seq
  import vcr_pkg::*;
#(
  parameter int SPEC_W = 3,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [BSEL_W-1:0] cmd_sel,
  input  logic [SPEC_W-1:0] cmd_spec,
  input  logic [IDX_W:0]    cmd_vl,
  input  logic              flag_valid,
  output logic              flag_ready,
  output logic              wr_en,
  output logic [BSEL_W-1:0] sel_q,
  output logic [SPEC_W-1:0] spec_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              idle,
  output logic              done
);
  seq_state_e     state;
  logic [IDX_W:0] vl_q;
  logic           last;

  assign idle       = (state == SQ_IDLE);
  assign cmd_ready  = idle;
  assign flag_ready = (state == SQ_RUN);
  assign done       = (state == SQ_FIN);
  assign wr_en      = flag_valid && flag_ready;
  assign last       = ({1'b0, idx_q} == (vl_q - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      vl_q   <= '0;
      idx_q  <= '0;
      sel_q  <= '0;
      spec_q <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (cmd_valid) begin
            sel_q  <= cmd_sel;
            spec_q <= cmd_spec;
            vl_q   <= cmd_vl;
            idx_q  <= '0;
            state  <= (cmd_vl == '0) ? SQ_FIN : SQ_RUN;
          end
        end
        SQ_RUN: begin
          if (wr_en) begin
            if (last) state <= SQ_FIN;
            else      idx_q <= idx_q + 1'b1;
          end
        end
        SQ_FIN:  state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vcr_file.sv
module vcr_file
  import vcr_pkg::*;
#(
  parameter int SPEC_W = 3,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [4:0]        cmd_sel,
  input  logic [SPEC_W-1:0] cmd_spec,
  input  logic [IDX_W:0]    cmd_vl,
  input  logic              flag_valid,
  output logic              flag_ready,
  input  logic [3:0]        flag_data,
  output logic              done,
  input  logic              bw_valid,
  output logic              bw_ready,
  input  logic [4:0]        bw_sel,
  input  logic [SPEC_W-1:0] bw_spec,
  input  logic [IDX_W-1:0]  bw_idx,
  input  logic              bw_data,
  input  logic [4:0]        rd_sel,
  input  logic [SPEC_W-1:0] rd_spec,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [3:0]        rd_field,
  output logic              rd_bit
);
  vcr_loc_t                    rd_loc, bw_loc, sq_loc, w_loc;
  logic                        sq_wr, sq_idle, bw_fire, we;
  logic [BSEL_W-1:0]           sq_sel;
  logic [SPEC_W-1:0]           sq_spec;
  logic [IDX_W-1:0]            sq_idx;
  logic [FLD_W-1:0]            wmask, wdata;
  logic [NROWS-1:0][ROW_W-1:0] rows_w;

  vcr_seq #(.SPEC_W(SPEC_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_sel(cmd_sel), .cmd_spec(cmd_spec), .cmd_vl(cmd_vl),
    .flag_valid(flag_valid), .flag_ready(flag_ready),
    .wr_en(sq_wr), .sel_q(sq_sel), .spec_q(sq_spec), .idx_q(sq_idx),
    .idle(sq_idle), .done(done)
  );

  vcr_addr #(.SPEC_W(SPEC_W), .IDX_W(IDX_W)) u_rd_addr (
    .sel(rd_sel), .spec(rd_spec), .idx(rd_idx), .loc(rd_loc)
  );
  vcr_addr #(.SPEC_W(SPEC_W), .IDX_W(IDX_W)) u_bw_addr (
    .sel(bw_sel), .spec(bw_spec), .idx(bw_idx), .loc(bw_loc)
  );
  vcr_addr #(.SPEC_W(SPEC_W), .IDX_W(IDX_W)) u_sq_addr (
    .sel(sq_sel), .spec(sq_spec), .idx(sq_idx), .loc(sq_loc)
  );

  // bit writes are accepted only while idle, sequencer writes only while running
  assign bw_ready = sq_idle;
  assign bw_fire  = bw_valid && bw_ready;
  assign we       = sq_wr || bw_fire;

  always_comb begin
    if (sq_wr) begin
      w_loc = sq_loc;
      wmask = '1;
      wdata = flag_data;
    end else begin
      w_loc = bw_loc;
      wmask = FLD_W'(1) << bw_loc.bitn;
      wdata = {FLD_W{bw_data}};
    end
  end

  vcr_store u_store (
    .clk(clk), .rst_n(rst_n),
    .we(we), .wrow(w_loc.row), .wcol(w_loc.col), .wmask(wmask), .wdata(wdata),
    .rrow(rd_loc.row), .rcol(rd_loc.col), .rfield(rd_field), .rows_q(rows_w)
  );

  assign rd_bit = rd_field[rd_loc.bitn];
endmodule

// File: rtl/vcr_file_chk.sv
module vcr_file_chk
  import vcr_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cmd_valid,
  input logic                        cmd_ready,
  input logic [IDX_W:0]              cmd_vl,
  input logic                        flag_valid,
  input logic                        flag_ready,
  input logic                        bw_valid,
  input logic                        bw_ready,
  input logic                        done,
  input logic [NROWS-1:0][ROW_W-1:0] rows
);
  logic [IDX_W:0] acc_cnt;
  logic [IDX_W:0] vl_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      vl_seen <= '0;
    end else if (cmd_valid && cmd_ready) begin
      acc_cnt <= '0;
      vl_seen <= cmd_vl;
    end else if (flag_valid && flag_ready) begin
      acc_cnt <= acc_cnt + 1'b1;
    end
  end

  // R9: completion pulse lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: empty vector completes right after acceptance
  p_vl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_vl == '0) |=> done);

  // R7: exactly VL nibbles are consumed before completion
  p_elem_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (acc_cnt == vl_seen));

  // R11: flag stream and idle-side ports are never ready together
  p_ready_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_ready && (cmd_ready || bw_ready)));

  // R6: storage changes only through an accepted transfer
  p_no_stray_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bw_valid && bw_ready) && !(flag_valid && flag_ready)) |=> $stable(rows));
endmodule

bind vcr_file vcr_file_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_vl(cmd_vl),
  .flag_valid(flag_valid), .flag_ready(flag_ready),
  .bw_valid(bw_valid), .bw_ready(bw_ready),
  .done(done), .rows(rows_w)
);

// File: tb/vcr_file_tb.sv
`timescale 1ns/1ps
module vcr_file_tb;
  localparam int SPEC_W = 3;
  localparam int IDX_W  = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid = 0, flag_valid = 0, bw_valid = 0, bw_data = 0;
  logic cmd_ready, flag_ready, bw_ready, done, rd_bit;
  logic [4:0] cmd_sel = 0, bw_sel = 0, rd_sel = 0;
  logic [SPEC_W-1:0] cmd_spec = 0, bw_spec = 0, rd_spec = 0;
  logic [IDX_W:0] cmd_vl = 0;
  logic [IDX_W-1:0] bw_idx = 0, rd_idx = 0;
  logic [3:0] flag_data = 0, rd_field;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_rows [16];
  int e_mode = 0, e_cnt = 0, e_vl = 0, e_sel = 0, e_spec = 0;

  always #2.5 clk = ~clk;

  vcr_file #(.SPEC_W(SPEC_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_sel(cmd_sel),
    .cmd_spec(cmd_spec), .cmd_vl(cmd_vl),
    .flag_valid(flag_valid), .flag_ready(flag_ready), .flag_data(flag_data),
    .done(done),
    .bw_valid(bw_valid), .bw_ready(bw_ready), .bw_sel(bw_sel), .bw_spec(bw_spec),
    .bw_idx(bw_idx), .bw_data(bw_data),
    .rd_sel(rd_sel), .rd_spec(rd_spec), .rd_idx(rd_idx),
    .rd_field(rd_field), .rd_bit(rd_bit)
  );

  // reference mapping, written from the requirement text
  function automatic int m_row(int sel, int idx);
    return ((7 - sel / 4) + idx % 16) % 16;
  endfunction
  function automatic int m_col(int sel, int spec, int idx);
    int sp3 = (SPEC_W == 2) ? spec * 2 : spec;
    int ext = (7 - sel / 4) * 16 + (sp3 / 2) * 4;
    return (ext + idx / 16) % 8;
  endfunction
  function automatic int m_lsb(int sel, int spec, int idx);
    return (7 - m_col(sel, spec, idx)) * 4;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // inputs are already driven; compare before the edge, update model, advance
  task automatic tick(string tag);
    int r, lsb, ef, eb;
    #1;
    r   = m_row(rd_sel, rd_idx);
    lsb = m_lsb(rd_sel, rd_spec, rd_idx);
    ef  = int'((m_rows[r] >> lsb) & 32'hf);
    eb  = (ef >> (3 - rd_sel % 4)) & 1;
    chk(rd_field == 4'(ef) && rd_bit == 1'(eb), tag, "read field/bit",
        int'({rd_field, rd_bit}), ef * 2 + eb);
    chk(done == (e_mode == 2), "R9", "done", int'(done), int'(e_mode == 2));
    chk(cmd_ready == (e_mode == 0) && bw_ready == (e_mode == 0) &&
        flag_ready == (e_mode == 1), "R11", "readies",
        int'({cmd_ready, bw_ready, flag_ready}),
        int'({e_mode == 0, e_mode == 0, e_mode == 1}));
    if (e_mode == 1) begin
      if (flag_valid) begin
        int wr = m_row(e_sel, e_cnt);
        int wl = m_lsb(e_sel, e_spec, e_cnt);
        m_rows[wr] = (m_rows[wr] & ~(32'hf << wl)) | (32'(flag_data) << wl);
        if (e_cnt == e_vl - 1) e_mode = 2;
        else e_cnt++;
      end
    end else if (e_mode == 0) begin
      if (bw_valid) begin
        int wr = m_row(bw_sel, bw_idx);
        int bp = m_lsb(bw_sel, bw_spec, bw_idx) + 3 - bw_sel % 4;
        m_rows[wr] = (m_rows[wr] & ~(32'h1 << bp)) | (32'(bw_data) << bp);
      end
      if (cmd_valid) begin
        e_sel = cmd_sel; e_spec = cmd_spec; e_vl = cmd_vl; e_cnt = 0;
        e_mode = (cmd_vl == 0) ? 2 : 1;
      end
    end else begin
      e_mode = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sweep(string tag);
    for (int sp = 0; sp < 8; sp += 2)
      for (int s = 0; s < 32; s += 4)
        for (int i = 0; i < 32; i++) begin
          rd_sel = 5'(s + i % 4); rd_spec = SPEC_W'(sp); rd_idx = IDX_W'(i * 5);
          tick(tag);
        end
  endtask

  task automatic bit_wr(int s, int sp, int i, bit d, string tag);
    bw_valid = 1; bw_sel = 5'(s); bw_spec = SPEC_W'(sp); bw_idx = IDX_W'(i); bw_data = d;
    rd_sel = 5'(s); rd_spec = SPEC_W'(sp); rd_idx = IDX_W'(i);
    tick(tag);  // same-edge read sees the old value
    bw_valid = 0;
    tick(tag);  // updated value visible
  endtask

  task automatic run_vec(int s, int sp, int vl, bit gaps, string tag);
    cmd_valid = 1; cmd_sel = 5'(s); cmd_spec = SPEC_W'(sp); cmd_vl = (IDX_W+1)'(vl);
    tick(tag);
    cmd_valid = 0;
    for (int e = 0; e < vl; ) begin
      flag_valid = !(gaps && e % 3 == 1 && e_cnt == e && flag_valid);
      flag_data  = 4'((e * 7 + s + 3) % 16);
      // a bit write and a command offered mid-run must change nothing (R11)
      bw_valid = gaps; bw_sel = 5'(s); bw_spec = SPEC_W'(sp); bw_idx = IDX_W'(e); bw_data = 1;
      cmd_valid = gaps;
      rd_sel = 5'(s); rd_spec = SPEC_W'(sp); rd_idx = IDX_W'(e);
      if (flag_valid) e++;
      tick(tag);
    end
    flag_valid = 0; bw_valid = 0; cmd_valid = 0;
    tick("R9");  // done cycle
    tick("R9");
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < 16; r++) m_rows[r] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1");
    // R2/R10: assorted single-bit writes, read back at the same location
    for (int k = 0; k < 24; k++) bit_wr((k * 7) % 32, k % 8, (k * 13) % 128, 1'b1, "R10");
    sweep("R2");
    // R6: clear some bits again; neighbours must survive
    for (int k = 0; k < 24; k += 3) bit_wr((k * 7) % 32, k % 8, (k * 13) % 128, 1'b0, "R6");
    // R3: write with spec bit0 set, read with it clear
    bit_wr(9, 5, 3, 1'b1, "R3");
    rd_sel = 9; rd_spec = 4; rd_idx = 3; tick("R3");
    // R4: field 7, index 12 wraps to row 3; read back through field 3, index 0
    bit_wr(2, 0, 12, 1'b1, "R4");
    rd_sel = 18; rd_spec = 0; rd_idx = 0; tick("R4");
    // R5: high index bits move the column
    bit_wr(21, 2, 16 * 5 + 4, 1'b1, "R5");
    rd_sel = 21; rd_spec = 2; rd_idx = 16 * 5 + 4; tick("R5");
    // R8: VL=18 from field 0
    run_vec(28, 0, 18, 1'b0, "R8");
    sweep("R8");
    // R9: empty vector, then a single element
    run_vec(12, 1, 0, 1'b0, "R9");
    run_vec(12, 1, 1, 1'b0, "R9");
    // R7/R11: longer vector in the upper column half with gaps and blocked requests
    run_vec(9, 6, 20, 1'b1, "R7");
    sweep("R7");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule